// File: doc/BRIEF.md
# Interlocked Bus Master Sequencer

This block runs one read or write transfer on a fully interlocked master/slave bus for a local requester. It first asks for bus mastership and waits for a grant. Once granted, it holds busy and places the address, the direction and any write data on the bus. After a settling delay it raises master sync. It then waits for the slave to answer with slave sync, which takes as long as the slave needs. After seeing the answer it waits a skew interval, captures read data, drops master sync and waits a trailing interval. Only then does it release the bus and report completion.

All timing is counted in cycles of the local clock. Slave sync is asynchronous to that clock and passes through a two-flop synchronizer before the sequencer uses it. If the slave never answers, a programmable timeout ends the cycle. Master sync is then released and completion is reported with an error flag.

Top module: `bus_master_seq`

## Requirements
- R1: After reset, bus_req, bus_busy, bus_msync, bus_dout_en, done and err are all low.
- R2: A req pulse accepted while idle raises bus_req from the next cycle. bus_req stays high and bus_busy stays low until bus_grant is seen. bus_req falls in the cycle that bus_busy rises.
- R3: Once granted, bus_busy is high and bus_addr carries the requested address for exactly DESKEW cycles before bus_msync rises. bus_addr holds that value for as long as bus_busy is high.
- R4: bus_dout_en is high throughout a write while bus_busy is high, with bus_dout equal to the write data. On a read, bus_dout_en stays low.
- R5: bus_msync stays high while the slave has not answered. After bus_ssync rises, bus_msync stays high for exactly 2 + SKEW more cycles: two cycles of synchronizer and SKEW cycles of skew wait.
- R6: Read data is sampled from bus_din in the last skew cycle, so rd_data is unaffected by any change to bus_din after bus_msync falls.
- R7: After bus_msync falls, bus_busy stays high for exactly TRAIL cycles. done then pulses for one cycle, in the first cycle with bus_busy low.
- R8: If no answer is seen, bus_msync stays high for exactly TIMEOUT cycles. The transfer then ends through the trailing delay, and done is raised together with err = 1. On a normal completion err is 0.
- R9: The length of the master sync phase follows the slave latency one-for-one: answering L cycles later lengthens it by L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Transfer request pulse, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rd_data | output | DW | Captured read data |
| bus_req | output | 1 | Mastership request |
| bus_grant | input | 1 | Mastership grant |
| bus_busy | output | 1 | Bus held by this master |
| bus_addr | output | AW | Address driven on the bus |
| bus_write | output | 1 | Direction driven on the bus |
| bus_dout | output | DW | Write data driven on the bus |
| bus_dout_en | output | 1 | Write data enable |
| bus_msync | output | 1 | Master sync |
| bus_ssync | input | 1 | Slave sync, asynchronous |
| bus_din | input | DW | Read data from the slave |

## Verification
The hardest situation to reach from the ports is the exact timing around slave sync. The answer is seen through the synchronizer, and data capture must happen before the slave may change the data. The bench slave answers after several different latencies and counts master sync cycles against each latency. As soon as master sync falls, it replaces the read data with its inverse, so a late capture shows up as wrong data. The timeout path is reached by a slave that never answers a chosen request.

// File: rtl/bus_master_seq.sv
module bus_master_seq #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int DESKEW  = 3,
  parameter int SKEW    = 2,
  parameter int TRAIL   = 2,
  parameter int TIMEOUT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_busy,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  output logic          bus_msync,
  input  logic          bus_ssync,
  input  logic [DW-1:0] bus_din
);

  localparam int MAXD = (TIMEOUT > DESKEW) ? ((TIMEOUT > SKEW) ? ((TIMEOUT > TRAIL) ? TIMEOUT : TRAIL)
                                                               : ((SKEW > TRAIL) ? SKEW : TRAIL))
                                           : ((DESKEW > SKEW) ? ((DESKEW > TRAIL) ? DESKEW : TRAIL)
                                                              : ((SKEW > TRAIL) ? SKEW : TRAIL));
  localparam int CW = $clog2(MAXD + 1);
  localparam logic [CW-1:0] DESKEW_LAST  = CW'(DESKEW - 1);
  localparam logic [CW-1:0] SKEW_LAST    = CW'(SKEW - 1);
  localparam logic [CW-1:0] TRAIL_LAST   = CW'(TRAIL - 1);
  localparam logic [CW-1:0] TIMEOUT_LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_SETUP, S_WAIT, S_SKEW, S_TRAIL} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          ss_meta, ss_sync;
  logic          wr_q, err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_meta <= 1'b0;
      ss_sync <= 1'b0;
    end else begin
      ss_meta <= bus_ssync;
      ss_sync <= ss_meta;
    end
  end

  assign bus_req     = (state == S_ARB);
  assign bus_busy    = (state == S_SETUP) || (state == S_WAIT) || (state == S_SKEW) || (state == S_TRAIL);
  assign bus_msync   = (state == S_WAIT) || (state == S_SKEW);
  assign bus_addr    = bus_busy ? addr_q : '0;
  assign bus_write   = bus_busy & wr_q;
  assign bus_dout_en = bus_busy & wr_q;
  assign bus_dout    = bus_dout_en ? wdata_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          err_q   <= 1'b0;
          state   <= S_ARB;
        end
        S_ARB: if (bus_grant) begin
          cnt   <= '0;
          state <= S_SETUP;
        end
        S_SETUP: if (cnt == DESKEW_LAST) begin
          cnt   <= '0;
          state <= S_WAIT;
        end else cnt <= cnt + 1'b1;
        S_WAIT: if (ss_sync) begin
          cnt   <= '0;
          state <= S_SKEW;
        end else if (cnt == TIMEOUT_LAST) begin
          cnt   <= '0;
          err_q <= 1'b1;
          state <= S_TRAIL;
        end else cnt <= cnt + 1'b1;
        S_SKEW: if (cnt == SKEW_LAST) begin
          if (!wr_q) rd_data <= bus_din;
          cnt   <= '0;
          state <= S_TRAIL;
        end else cnt <= cnt + 1'b1;
        S_TRAIL: if (cnt == TRAIL_LAST) begin
          cnt   <= '0;
          done  <= 1'b1;
          err   <= err_q;
          state <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_busy_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_busy));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && $past(bus_busy)) |-> $stable(bus_addr));

  assert_msync_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_msync |-> bus_busy);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_busy && $past(bus_busy)));

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (cnt < CW'(TIMEOUT)));

endmodule

// File: tb/bus_master_seq_tb.sv
module bus_master_seq_tb;
  localparam int AW = 16, DW = 16, DESKEW = 3, SKEW = 2, TRAIL = 2, TIMEOUT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic done, err, bus_req, bus_busy, bus_write, bus_dout_en, bus_msync;
  logic [DW-1:0] rd_data, bus_dout;
  logic [AW-1:0] bus_addr;
  logic bus_grant = 1'b0, bus_ssync = 1'b0;
  logic [DW-1:0] bus_din = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  bus_master_seq #(.AW(AW), .DW(DW), .DESKEW(DESKEW), .SKEW(SKEW), .TRAIL(TRAIL), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .err(err), .rd_data(rd_data), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_busy(bus_busy), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_msync(bus_msync),
    .bus_ssync(bus_ssync), .bus_din(bus_din));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // lat < 0 : slave never answers
  task automatic transfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int lat);
    int n;
    int msync_cnt;
    logic bad;
    @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0; req_addr = '0; req_wdata = '0;
    chk("R2 bus_req after req", 32'(bus_req), 1);
    bad = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (!bus_req || bus_busy) bad = 1'b1;
      @(negedge clk);
    end
    chk("R2 req held, busy low before grant", 32'(bad), 0);
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    chk("R2 busy on grant", 32'(bus_busy), 1);
    chk("R2 bus_req drops on grant", 32'(bus_req), 0);
    n = 0; bad = 1'b0;
    while (!bus_msync && n < 100) begin
      if (bus_busy) n++;
      if (bus_addr !== a) bad = 1'b1;
      @(negedge clk);
    end
    chk("R3 deskew cycles", 32'(n), 32'(DESKEW));
    chk("R3 address driven during setup", 32'(bad), 0);
    chk("R4 dout enable", 32'(bus_dout_en), 32'(wr));
    if (wr) chk("R4 write data on bus", 32'(bus_dout), 32'(d));
    msync_cnt = 0; bad = 1'b0;
    if (lat < 0) begin
      while (bus_msync && msync_cnt < 1000) begin
        msync_cnt++;
        if (bus_addr !== a || bus_dout_en !== wr) bad = 1'b1;
        @(negedge clk);
      end
      chk("R8 timeout length", 32'(msync_cnt), 32'(TIMEOUT));
    end else begin
      for (int i = 0; i < lat; i++) begin
        msync_cnt++;
        if (!bus_msync) bad = 1'b1;
        @(negedge clk);
      end
      chk("R5 msync held while slave silent", 32'(bad), 0);
      bus_ssync = 1'b1;
      bus_din = d;
      n = 0;
      msync_cnt++;
      @(negedge clk);
      while (bus_msync && n < 1000) begin
        n++;
        if (bus_addr !== a) bad = 1'b1;
        @(negedge clk);
      end
      msync_cnt += n;
      chk("R5 msync after ssync", 32'(n), 32'(2 + SKEW));
      chk("R9 msync phase vs latency", 32'(msync_cnt), 32'(lat + 3 + SKEW));
      bus_ssync = 1'b0;
      bus_din = ~d;
    end
    n = 0;
    while (bus_busy && n < 100) begin
      n++;
      if (done) bad = 1'b1;
      @(negedge clk);
    end
    chk("R7 trailing cycles", 32'(n), 32'(TRAIL));
    chk("R3 address stable while busy", 32'(bad), 0);
    chk("R7 done after busy", 32'(done), 1);
    chk("R8 err flag", 32'(err), (lat < 0) ? 1 : 0);
    if (!wr && lat >= 0) chk("R6 read data captured", 32'(rd_data), 32'(d));
    @(negedge clk);
    chk("R7 done single pulse", 32'(done), 0);
    bus_din = '0;
  endtask

  task automatic test_reset();
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 busy", 32'(bus_busy), 0);
    chk("R1 msync", 32'(bus_msync), 0);
    chk("R1 dout_en", 32'(bus_dout_en), 0);
    chk("R1 done/err", 32'({done, err}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    transfer(1'b0, 16'h1234, 16'hBEEF, 0);
    transfer(1'b1, 16'h00F0, 16'hA55A, 1);
    transfer(1'b0, 16'hFFFE, 16'h0F0F, 7);
    transfer(1'b1, 16'h4000, 16'h1357, 12);
    transfer(1'b0, 16'h2222, 16'h7777, -1);
    transfer(1'b0, 16'h3333, 16'hC3C3, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule